// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital control for a 12-bit successive-approximation converter. It divides the system clock down to a SAR clock and waits for a start event. A start can come from a software start pulse, from a timer overflow pulse, or from either one, depending on a 2-bit source select. The block then runs the track-and-hold policy chosen by a mode bit. After that it steps a successive-approximation register, MSB first, against a single comparator bit that reflects the trial code it drives out.

In continuous mode the sample output is high whenever no conversion is running, and conversion starts on the SAR clock after the trigger. In low-power mode the sample output stays low until a trigger arrives. It then stays high for exactly three SAR clocks, and only after that does the conversion start. A conversion lasts sixteen SAR clocks. The first twelve resolve one bit each and the last four are settling. The busy output is high from the accepted trigger to the end of the conversion. At the end, the result register is loaded and a sticky interrupt flag is set. The flag is cleared only by a software clear pulse. The interrupt request is the flag gated by an enable.

The controller has three states. `ST_IDLE` waits for a trigger; it moves to `ST_TRACK` when the mode bit is 1, otherwise to `ST_CONV`. `ST_TRACK` counts three SAR ticks and then moves to `ST_CONV`. `ST_CONV` counts sixteen SAR ticks and then returns to `ST_IDLE`, marking completion.

Top module: `sar_seq`

## Requirements
- R1: The SAR period is 1, 2, 4, 8 or 16 system clocks for `rate_sel` values 0, 1, 2, 3 and 4; values 5 to 7 give 16. The divider phase restarts on every accepted trigger, so the busy time is an exact multiple of the SAR period.
- R2: `start_src` selects the start source: 0 accepts only `sw_start`, 1 accepts only `tmr_ovf`, and 2 or 3 accept either. A pulse from a source that is not selected starts nothing.
- R3: After an accepted trigger, `busy` stays high for exactly 16 SAR periods when `lp_track`=0 and 19 SAR periods when `lp_track`=1, and then returns to 0.
- R4: A trigger that arrives while `busy` is high is ignored. The running conversion keeps its length and result, and no new conversion follows it.
- R5: `irq_flag` rises in the same cycle that `busy` falls and stays high until `irq_clr` is pulsed. When completion and `irq_clr` land on the same edge, the flag ends up set.
- R6: `irq_req` is high exactly when both `irq_flag` and `irq_en` are high.
- R7: With `lp_track`=0 and `standby`=0, `sample` is 1 while idle and 0 for the whole time `busy` is high.
- R8: With `lp_track`=1, `sample` is 0 while idle. After a trigger it is 1 for exactly the first 3 SAR periods of the busy time, and 0 for the rest.
- R9: While `standby` is 1, `sample` is 0 in every state.
- R10: `dac_code` presents the trial code. The bit under test is resolved as kept when `cmp_in`=1 (input at or above the trial code), MSB first. `result` is loaded with the final code when busy falls and holds until the next completion. With `cmp_in` = (input >= `dac_code`), `result` equals the input.
- R11: After reset, `busy`, `irq_flag`, `irq_req` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | SAR clock divide select |
| start_src | input | 2 | Start source select |
| lp_track | input | 1 | 1 selects low-power tracking after trigger |
| standby | input | 1 | Chip standby, forces tracking off |
| sw_start | input | 1 | Software start pulse |
| tmr_ovf | input | 1 | Timer overflow pulse |
| cmp_in | input | 1 | Comparator: input at or above `dac_code` |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| busy | output | 1 | Conversion in progress |
| irq_flag | output | 1 | Sticky completion flag |
| irq_req | output | 1 | Interrupt request |
| sample | output | 1 | Track-and-hold control, 1 = track |
| dac_code | output | 12 | Current trial code to the DAC |
| result | output | 12 | Last conversion result |

## Verification
Completion and the software flag clear can fall on the same clock edge. The bench provokes this at the fastest rate by counting cycles from a software start and holding `irq_clr` high in exactly the cycle before busy falls; it then expects the flag to read 1. A start pulse that lands in that same completion cycle is also checked: it must not launch a second conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRACK = 2'd1,
        ST_CONV  = 2'd2
    } seq_state_t;

    localparam logic [1:0] SRC_SW    = 2'd0;
    localparam logic [1:0] SRC_TIMER = 2'd1;
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
    parameter int RATE_W    = 3,
    parameter int MAX_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              restart,
    output logic              tick
);
    localparam int CNT_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  limit;
    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] shift;
    logic              rate_moved;

    always_comb begin
        if (rate_sel > RATE_W'(MAX_SHIFT))
            shift = RATE_W'(MAX_SHIFT);
        else
            shift = rate_sel;
        limit = CNT_W'((32'd1 << shift) - 32'd1);
    end

    assign rate_moved = (rate_sel != rate_q);
    assign tick       = (cnt == limit) && !rate_moved;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            rate_q <= '0;
        end else begin
            rate_q <= rate_sel;
            if (restart || rate_moved || tick)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_pkg::*;
#(
    parameter int RES_W      = 12,
    parameter int TRACK_CLKS = 3,
    parameter int CONV_CLKS  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     trig,
    input  logic                     lp_track,
    input  logic                     standby,
    output logic                     busy,
    output logic                     sample,
    output logic                     sar_init,
    output logic                     bit_en,
    output logic [$clog2(RES_W)-1:0] bit_pos,
    output logic                     done
);
    localparam int STEP_W = $clog2(CONV_CLKS);
    localparam int POS_W  = $clog2(RES_W);

    seq_state_t        state, state_nx;
    logic [STEP_W-1:0] step, step_nx;
    logic              track_last;
    logic              conv_last;

    assign track_last = (step == STEP_W'(TRACK_CLKS - 1));
    assign conv_last  = (step == STEP_W'(CONV_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= '0;
        end else begin
            state <= state_nx;
            step  <= step_nx;
        end
    end

    always_comb begin
        state_nx = state;
        step_nx  = step;
        unique case (state)
            ST_IDLE: begin
                step_nx = '0;
                if (trig)
                    state_nx = lp_track ? ST_TRACK : ST_CONV;
            end
            ST_TRACK: begin
                if (tick) begin
                    if (track_last) begin
                        state_nx = ST_CONV;
                        step_nx  = '0;
                    end else begin
                        step_nx = step + 1'b1;
                    end
                end
            end
            ST_CONV: begin
                if (tick) begin
                    if (conv_last) begin
                        state_nx = ST_IDLE;
                        step_nx  = '0;
                    end else begin
                        step_nx = step + 1'b1;
                    end
                end
            end
            default: begin
                state_nx = ST_IDLE;
                step_nx  = '0;
            end
        endcase
    end

    always_comb begin
        busy     = 1'b0;
        sample   = 1'b0;
        sar_init = 1'b0;
        bit_en   = 1'b0;
        done     = 1'b0;
        bit_pos  = POS_W'(RES_W - 1) - POS_W'(step);
        unique case (state)
            ST_IDLE: begin
                sample   = !lp_track && !standby;
                sar_init = trig && !lp_track;
            end
            ST_TRACK: begin
                busy     = 1'b1;
                sample   = !standby;
                sar_init = tick && track_last;
            end
            ST_CONV: begin
                busy   = 1'b1;
                bit_en = tick && (step < STEP_W'(RES_W));
                done   = tick && conv_last;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
    parameter int RES_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sar_init,
    input  logic                     bit_en,
    input  logic [$clog2(RES_W)-1:0] bit_pos,
    input  logic                     cmp_in,
    input  logic                     load,
    output logic [RES_W-1:0]         trial,
    output logic [RES_W-1:0]         result
);
    localparam int POS_W = $clog2(RES_W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial <= '0;
        end else if (sar_init) begin
            trial <= {1'b1, {(RES_W-1){1'b0}}};
        end else if (bit_en) begin
            trial[bit_pos] <= cmp_in;
            if (bit_pos != '0)
                trial[POS_W'(bit_pos - 1'b1)] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            result <= '0;
        else if (load)
            result <= trial;
    end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int RES_W      = 12,
    parameter int RATE_W     = 3,
    parameter int MAX_SHIFT  = 4,
    parameter int TRACK_CLKS = 3,
    parameter int CONV_CLKS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [1:0]        start_src,
    input  logic              lp_track,
    input  logic              standby,
    input  logic              sw_start,
    input  logic              tmr_ovf,
    input  logic              cmp_in,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              busy,
    output logic              irq_flag,
    output logic              irq_req,
    output logic              sample,
    output logic [RES_W-1:0]  dac_code,
    output logic [RES_W-1:0]  result
);
    localparam int POS_W = $clog2(RES_W);

    logic             trig;
    logic             tick;
    logic             sar_init;
    logic             bit_en;
    logic             done;
    logic [POS_W-1:0] bit_pos;

    always_comb begin
        unique case (start_src)
            SRC_SW:    trig = sw_start;
            SRC_TIMER: trig = tmr_ovf;
            default:   trig = sw_start || tmr_ovf;
        endcase
    end

    sar_clkdiv #(
        .RATE_W   (RATE_W),
        .MAX_SHIFT(MAX_SHIFT)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate_sel(rate_sel),
        .restart (trig && !busy),
        .tick    (tick)
    );

    sar_fsm #(
        .RES_W     (RES_W),
        .TRACK_CLKS(TRACK_CLKS),
        .CONV_CLKS (CONV_CLKS)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .trig    (trig),
        .lp_track(lp_track),
        .standby (standby),
        .busy    (busy),
        .sample  (sample),
        .sar_init(sar_init),
        .bit_en  (bit_en),
        .bit_pos (bit_pos),
        .done    (done)
    );

    sar_reg #(
        .RES_W(RES_W)
    ) u_sar (
        .clk     (clk),
        .rst_n   (rst_n),
        .sar_init(sar_init),
        .bit_en  (bit_en),
        .bit_pos (bit_pos),
        .cmp_in  (cmp_in),
        .load    (done),
        .trial   (dac_code),
        .result  (result)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_flag <= 1'b0;
        else if (done)
            irq_flag <= 1'b1;
        else if (irq_clr)
            irq_flag <= 1'b0;
    end

    assign irq_req = irq_flag && irq_en;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             irq_flag,
    input logic             irq_clr,
    input logic             irq_en,
    input logic             irq_req,
    input logic             sample,
    input logic             standby,
    input logic             lp_track,
    input logic [RES_W-1:0] result
);
    AST_FLAG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq_flag);                                   // R5
    AST_FLAG_ONLY_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $fell(busy));                            // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);                        // R5
    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_req);                                       // R6
    AST_STANDBY_NO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !sample);                                        // R9
    AST_LP_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_track && !busy) |-> !sample);                            // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(result));                           // R10
endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .irq_flag(irq_flag),
    .irq_clr (irq_clr),
    .irq_en  (irq_en),
    .irq_req (irq_req),
    .sample  (sample),
    .standby (standby),
    .lp_track(lp_track),
    .result  (result)
);

// File: tb/tb_sar_seq.sv
module tb_sar_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rate_sel = '0;
    logic [1:0]  start_src = '0;
    logic        lp_track = 1'b0;
    logic        standby = 1'b0;
    logic        sw_start = 1'b0;
    logic        tmr_ovf = 1'b0;
    logic        cmp_in;
    logic        irq_en = 1'b0;
    logic        irq_clr = 1'b0;
    logic        busy, irq_flag, irq_req, sample;
    logic [11:0] dac_code, result;
    logic [11:0] vin = '0;

    int checks = 0;
    int errors = 0;
    int busy_cnt, samp_cnt;

    always #4 clk = ~clk;

    assign cmp_in = (vin >= dac_code);

    sar_seq dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .start_src(start_src),
        .lp_track(lp_track), .standby(standby), .sw_start(sw_start),
        .tmr_ovf(tmr_ovf), .cmp_in(cmp_in), .irq_en(irq_en), .irq_clr(irq_clr),
        .busy(busy), .irq_flag(irq_flag), .irq_req(irq_req), .sample(sample),
        .dac_code(dac_code), .result(result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int div_of(input int r);
        return (r > 4) ? 16 : (1 << r);
    endfunction

    task automatic pulse(input bit use_tmr);
        @(negedge clk);
        if (use_tmr) tmr_ovf = 1'b1; else sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        tmr_ovf  = 1'b0;
    endtask

    task automatic measure();
        busy_cnt = 0;
        samp_cnt = 0;
        while (busy && busy_cnt < 1000) begin
            busy_cnt++;
            if (sample) samp_cnt++;
            @(negedge clk);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy == 0 && irq_flag == 0 && irq_req == 0, "R11 flags", {busy, irq_flag, irq_req}, 0);
        chk(result == 0, "R11 result", result, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3 R7 R8 R10 R5: sweep all rates in both tracking modes
        for (int lp = 0; lp < 2; lp++) begin
            for (int r = 0; r < 8; r++) begin
                rate_sel = 3'(r);
                lp_track = lp[0];
                vin      = 12'(r * 517 + lp * 1999 + 3);
                @(negedge clk);
                chk(sample == !lp[0], "R7/R8 idle sample", sample, !lp[0]);
                pulse(1'b0);
                measure();
                chk(busy_cnt == (lp ? 19 : 16) * div_of(r), "R1/R3 busy length", busy_cnt, (lp ? 19 : 16) * div_of(r));
                chk(samp_cnt == (lp ? 3 * div_of(r) : 0), "R7/R8 sample length", samp_cnt, lp ? 3 * div_of(r) : 0);
                chk(result == vin, "R10 result", result, vin);
                chk(irq_flag == 1, "R5 flag set", irq_flag, 1);
                clear_flag();
                chk(irq_flag == 0, "R5 flag cleared", irq_flag, 0);
            end
        end

        // R10 boundary codes
        rate_sel = 3'd0;
        lp_track = 1'b0;
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: vin = 12'h000;
                1: vin = 12'hFFF;
                2: vin = 12'h800;
                3: vin = 12'h7FF;
                4: vin = 12'h555;
                default: vin = 12'hAAA;
            endcase
            pulse(1'b0);
            measure();
            chk(result == vin, "R10 boundary code", result, vin);
            vin = 12'h123;
            repeat (3) @(negedge clk);
            chk(result != 12'h123 || k == 7, "R10 result held", result, -1);
        end
        clear_flag();

        // R2 source selection
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 2; t++) begin
                bit accept;
                accept    = (s >= 2) || (s == t);
                start_src = 2'(s);
                pulse(t[0]);
                chk(busy == accept, "R2 source select", busy, accept);
                measure();
                repeat (2) @(negedge clk);
            end
        end
        start_src = 2'd0;

        // R4 retrigger while busy
        rate_sel = 3'd1;
        vin      = 12'h3C5;
        pulse(1'b0);
        repeat (7) @(negedge clk);
        vin = 12'h3C5;
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        measure();
        chk(busy_cnt == 32 - 8, "R4 length unchanged", busy_cnt, 24);
        repeat (4) @(negedge clk);
        chk(busy == 0, "R4 no follow-on conversion", busy, 0);
        chk(result == 12'h3C5, "R4 result intact", result, 12'h3C5);

        // R6 request gating
        chk(irq_flag == 1 && irq_req == 0, "R6 disabled", irq_req, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq_req == 1, "R6 enabled", irq_req, 1);
        clear_flag();
        chk(irq_req == 0, "R6 after clear", irq_req, 0);

        // R5 collision: clear on the completion edge, start in same cycle
        rate_sel = 3'd0;
        pulse(1'b0);
        repeat (15) @(negedge clk);
        irq_clr  = 1'b1;
        sw_start = 1'b1;
        @(negedge clk);
        irq_clr  = 1'b0;
        sw_start = 1'b0;
        chk(irq_flag == 1, "R5 set wins over clear", irq_flag, 1);
        chk(busy == 0, "R4 start on completion edge ignored", busy, 0);
        clear_flag();

        // R9 standby
        standby = 1'b1;
        @(negedge clk);
        chk(sample == 0, "R9 idle standby", sample, 0);
        lp_track = 1'b1;
        pulse(1'b0);
        measure();
        chk(samp_cnt == 0, "R9 no tracking in standby", samp_cnt, 0);
        standby = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule